// File: doc/BRIEF.md
# DMA Bus Sequencer and Register Access Port

This block is the system-bus edge of a multi-channel DMA controller. It has two roles, chosen by the bus-grant input. While the processor owns the bus, the block acts as a peripheral. It decodes the chip select, the two I/O strobes and a four-bit register index. From these it produces a one-cycle write pulse toward the controller's register file. It also drives the register file's read data onto the data bus.

While the controller owns the bus, the block runs one memory/I/O transfer for each request from the channel logic. A transfer steps through a fixed sequence of states:

1. The address goes out.
2. A latch strobe captures the upper address byte, which is placed on the shared data bus.
3. The active-low memory and I/O strobes are asserted. This phase lasts as long as the ready input holds it.
4. The strobes are released and completion is reported.

Tri-state pins are modelled as plain outputs with separate output-enable signals. Channel address arithmetic and arbitration belong to other blocks.

Top module: `dma_strobe_unit`

## Requirements
- R1: During and right after reset, the sequencer is idle. All four strobes (`iorNOut`, `iowNOut`, `memrN`, `memwN`) are high. `aen`, `adstb`, `dataOe`, `regWrEn` and `xferDone` are low.
- R2: Slave-mode write. The block is in slave mode when `busGrant` is low and it is idle. In that mode, the first clock edge that samples `csN`=0, `iowNIn`=0 and `iorNIn`=1 produces `regWrEn`=1 for exactly one cycle after that edge. During that cycle, `regWrSel` and `regWrData` show `addrLoIn` and `dataIn` as sampled at that edge. Holding the strobe low produces no further pulse.
- R3: Slave-mode read. In slave mode, while `csN`=0, `iorNIn`=0 and `iowNIn`=1, the block combinationally sets `dataOe`=1, `dataOut`=`regRdData` and `regRdSel`=`addrLoIn`.
- R4: A register access needs both `csN` low and slave mode. With `csN` high, or with `busGrant` high, no `regWrEn` pulse occurs and a low `iorNIn` does not raise `dataOe`.
- R5: A request is accepted at an edge where the block is idle and both `busGrant` and `xferReq` are high.
  - In the first cycle after that edge (address phase), `aen`=1, `adstb`=0, `dataOe`=1, `dataOut`=address bits 15..8, `addrLoOut`=bits 3..0 and `addrMidOut`=bits 7..4.
  - In the second cycle (latch phase), the same values hold, except that `adstb`=1.
  - No strobe is low in either phase.
- R6: Transfer kind is encoded on `xferKind`.
  - Kind 2'b01 moves data from I/O to memory. During the strobe phase it drives `iorNOut` and `memwN` low together.
  - Kind 2'b10 moves data from memory to I/O. During the strobe phase it drives `iowNOut` and `memrN` low together.
  - `dataOe` is 0 during the strobe phase.
- R7: Kinds 2'b00 (verify) and 2'b11 run the same cycle sequence but keep all four strobes high.
- R8: The strobe phase lasts at least one cycle. It is extended by one cycle for every edge inside it that samples `readyIn` low. It ends after the first edge that samples `readyIn` high.
- R9: The cycle after the strobe phase is the release phase: all strobes are high, `aen`=1 and `xferDone`=1 for one cycle. In the next cycle the block is idle again, with `aen`=0 and `xferDone`=0.
- R10: `busOe` follows `busGrant`. While `busGrant` is low and no transfer is in progress, all four strobes stay high.
- R11: `xferReq` is ignored while `busGrant` is low. It is also ignored while a transfer is in progress, so no second address phase overlaps the running one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busGrant | input | 1 | High when the processor has released the system bus |
| xferReq | input | 1 | Start one transfer (from channel logic) |
| xferKind | input | 2 | 00 verify, 01 I/O-to-memory, 10 memory-to-I/O, 11 treated as verify |
| xferAddr | input | 16 | Memory address of the transfer |
| readyIn | input | 1 | Low extends the strobe phase |
| xferDone | output | 1 | One-cycle pulse in the release phase |
| csN | input | 1 | Active-low chip select (slave mode) |
| iorNIn | input | 1 | Active-low register read strobe from the processor |
| iowNIn | input | 1 | Active-low register write strobe from the processor |
| addrLoIn | input | 4 | Register index from the processor |
| dataIn | input | 8 | Data bus input |
| regWrEn | output | 1 | One-cycle register write pulse |
| regWrSel | output | 4 | Register index for the write |
| regWrData | output | 8 | Data for the write |
| regRdSel | output | 4 | Register index for the read |
| regRdData | input | 8 | Read data from the register file |
| dataOut | output | 8 | Data bus output value |
| dataOe | output | 1 | Data bus output enable |
| busOe | output | 1 | Enable for the strobes and the address outputs |
| addrLoOut | output | 4 | Address bits 3..0 |
| addrMidOut | output | 4 | Address bits 7..4 |
| iorNOut | output | 1 | Active-low I/O read strobe |
| iowNOut | output | 1 | Active-low I/O write strobe |
| memrN | output | 1 | Active-low memory read strobe |
| memwN | output | 1 | Active-low memory write strobe |
| adstb | output | 1 | Upper address byte latch strobe |
| aen | output | 1 | Address enable, high through a transfer |

## Verification
The embedded properties watch the following on every cycle:
- the two I/O strobes are never low together;
- verify-type transfers stay quiet on all four strobes;
- the latch phase always leads into the strobe phase;
- a low ready keeps the strobe phase in place;
- completion and write pulses last a single cycle;
- a processor read never drives the data bus during a transfer.

Only the bench's scenarios can show the values themselves. These include the exact byte placed on the data bus and the address nibbles in each phase, the pairing of strobes to each kind, and the exact length of each wait-stretched phase. They also include the captured register index and data, and the fact that ignored requests and deselected accesses leave the ports untouched.

// File: rtl/dma_strobe_pkg.sv
`timescale 1ns/1ps
package dma_strobe_pkg;

  typedef enum logic [1:0] {
    KIND_VERIFY = 2'b00,
    KIND_IO2MEM = 2'b01,
    KIND_MEM2IO = 2'b10,
    KIND_SPARE  = 2'b11
  } xferKind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_LATCH,
    ST_STROBE,
    ST_RELEASE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadXfer;   // capture address and kind
    logic showAddr;   // upper byte on data bus
    logic latchPulse; // address latch strobe
    logic strobeOn;   // transfer strobes active
    logic finish;     // release phase
    logic inXfer;     // any non-idle state
    logic slaveMode;  // register access allowed
    logic wrCapture;  // take a register write this edge
  } seqCtrl_t;

endpackage

// File: rtl/dma_strobe_ctrl.sv
`timescale 1ns/1ps
module dma_strobe_ctrl
  import dma_strobe_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     busGrant,
  input  logic     xferReq,
  input  logic     readyIn,
  input  logic     csN,
  input  logic     iorNIn,
  input  logic     iowNIn,
  output seqCtrl_t ctrl
);

  seqState_t state, stateNext;
  logic wrHeld;
  logic wrCond;
  logic accept;

  assign accept = (state == ST_IDLE) && busGrant && xferReq;
  assign wrCond = !csN && !iowNIn && iorNIn;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (accept) stateNext = ST_ADDR;
      ST_ADDR:    stateNext = ST_LATCH;
      ST_LATCH:   stateNext = ST_STROBE;
      ST_STROBE:  if (readyIn) stateNext = ST_RELEASE;
      ST_RELEASE: stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      wrHeld <= 1'b0;
    end else begin
      state  <= stateNext;
      wrHeld <= ctrl.slaveMode && wrCond;
    end
  end

  always_comb begin
    ctrl.loadXfer   = accept;
    ctrl.showAddr   = (state == ST_ADDR) || (state == ST_LATCH);
    ctrl.latchPulse = (state == ST_LATCH);
    ctrl.strobeOn   = (state == ST_STROBE);
    ctrl.finish     = (state == ST_RELEASE);
    ctrl.inXfer     = (state != ST_IDLE);
    ctrl.slaveMode  = !busGrant && (state == ST_IDLE);
    ctrl.wrCapture  = !busGrant && (state == ST_IDLE) && wrCond && !wrHeld;
  end

  AST_LATCH_TO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LATCH) |=> (state == ST_STROBE)); // R5

  AST_READY_WAIT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STROBE && !readyIn) |=> (state == ST_STROBE)); // R8

  AST_RELEASE_ONCE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RELEASE) |=> (state == ST_IDLE)); // R9

  AST_GRANT_NEEDED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !busGrant) |=> (state == ST_IDLE)); // R11

endmodule

// File: rtl/dma_strobe_dp.sv
`timescale 1ns/1ps
module dma_strobe_dp
  import dma_strobe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  seqCtrl_t            ctrl,
  input  logic [1:0]          xferKind,
  input  logic [2*DATA_W-1:0] xferAddr,
  input  logic                csN,
  input  logic                iorNIn,
  input  logic                iowNIn,
  input  logic [SEL_W-1:0]    addrLoIn,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic [DATA_W-1:0]   regRdData,
  output logic                regWrEn,
  output logic [SEL_W-1:0]    regWrSel,
  output logic [DATA_W-1:0]   regWrData,
  output logic [SEL_W-1:0]    regRdSel,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataOe,
  output logic [SEL_W-1:0]    addrLoOut,
  output logic [DATA_W-SEL_W-1:0] addrMidOut,
  output logic                iorNOut,
  output logic                iowNOut,
  output logic                memrN,
  output logic                memwN,
  output logic                adstb,
  output logic                aen,
  output logic                xferDone
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam int MID_W  = DATA_W - SEL_W;

  logic [ADDR_W-1:0] addrQ;
  xferKind_t         kindQ;
  logic              rdDrive;
  logic              ioToMem;
  logic              memToIo;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ     <= '0;
      kindQ     <= KIND_VERIFY;
      regWrEn   <= 1'b0;
      regWrSel  <= '0;
      regWrData <= '0;
    end else begin
      if (ctrl.loadXfer) begin
        addrQ <= xferAddr;
        kindQ <= xferKind_t'(xferKind);
      end
      regWrEn <= ctrl.wrCapture;
      if (ctrl.wrCapture) begin
        regWrSel  <= addrLoIn;
        regWrData <= dataIn;
      end
    end
  end

  assign rdDrive  = ctrl.slaveMode && !csN && !iorNIn && iowNIn;
  assign regRdSel = addrLoIn;

  assign dataOut = ctrl.showAddr ? addrQ[ADDR_W-1:DATA_W] : regRdData;
  assign dataOe  = ctrl.showAddr || rdDrive;

  assign addrLoOut  = addrQ[SEL_W-1:0];
  assign addrMidOut = addrQ[SEL_W +: MID_W];

  assign ioToMem = ctrl.strobeOn && (kindQ == KIND_IO2MEM);
  assign memToIo = ctrl.strobeOn && (kindQ == KIND_MEM2IO);

  assign iorNOut = !ioToMem;
  assign memwN   = !ioToMem;
  assign iowNOut = !memToIo;
  assign memrN   = !memToIo;

  assign adstb    = ctrl.latchPulse;
  assign aen      = ctrl.inXfer;
  assign xferDone = ctrl.finish;

  AST_IO_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!iorNOut && !iowNOut)); // R6

  AST_VERIFY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (kindQ == KIND_VERIFY || kindQ == KIND_SPARE) |->
      (iorNOut && iowNOut && memrN && memwN)); // R7

  AST_RD_NOT_IN_XFER: assert property (@(posedge clk) disable iff (rst)
    rdDrive |-> !aen); // R4

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    regWrEn |=> !regWrEn); // R2

  AST_LATCH_ON_BUS: assert property (@(posedge clk) disable iff (rst)
    adstb |-> (dataOe && aen)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    xferDone |=> !xferDone); // R9

endmodule

// File: rtl/dma_strobe_unit.sv
`timescale 1ns/1ps
module dma_strobe_unit
  import dma_strobe_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        busGrant,
  input  logic        xferReq,
  input  logic [1:0]  xferKind,
  input  logic [15:0] xferAddr,
  input  logic        readyIn,
  output logic        xferDone,
  input  logic        csN,
  input  logic        iorNIn,
  input  logic        iowNIn,
  input  logic [3:0]  addrLoIn,
  input  logic [7:0]  dataIn,
  output logic        regWrEn,
  output logic [3:0]  regWrSel,
  output logic [7:0]  regWrData,
  output logic [3:0]  regRdSel,
  input  logic [7:0]  regRdData,
  output logic [7:0]  dataOut,
  output logic        dataOe,
  output logic        busOe,
  output logic [3:0]  addrLoOut,
  output logic [3:0]  addrMidOut,
  output logic        iorNOut,
  output logic        iowNOut,
  output logic        memrN,
  output logic        memwN,
  output logic        adstb,
  output logic        aen
);

  seqCtrl_t ctrl;

  dma_strobe_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .busGrant (busGrant),
    .xferReq  (xferReq),
    .readyIn  (readyIn),
    .csN      (csN),
    .iorNIn   (iorNIn),
    .iowNIn   (iowNIn),
    .ctrl     (ctrl)
  );

  dma_strobe_dp #(.DATA_W(8), .SEL_W(4)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .xferKind   (xferKind),
    .xferAddr   (xferAddr),
    .csN        (csN),
    .iorNIn     (iorNIn),
    .iowNIn     (iowNIn),
    .addrLoIn   (addrLoIn),
    .dataIn     (dataIn),
    .regRdData  (regRdData),
    .regWrEn    (regWrEn),
    .regWrSel   (regWrSel),
    .regWrData  (regWrData),
    .regRdSel   (regRdSel),
    .dataOut    (dataOut),
    .dataOe     (dataOe),
    .addrLoOut  (addrLoOut),
    .addrMidOut (addrMidOut),
    .iorNOut    (iorNOut),
    .iowNOut    (iowNOut),
    .memrN      (memrN),
    .memwN      (memwN),
    .adstb      (adstb),
    .aen        (aen),
    .xferDone   (xferDone)
  );

  assign busOe = busGrant;

  AST_RELEASED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!busGrant && !aen) |-> (iorNOut && iowNOut && memrN && memwN)); // R10

endmodule

// File: tb/dma_strobe_unit_test.sv
`timescale 1ns/1ps
module dma_strobe_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busGrant = 1'b0, xferReq = 1'b0, readyIn = 1'b1;
  logic [1:0]  xferKind = 2'b00;
  logic [15:0] xferAddr = '0;
  logic        csN = 1'b1, iorNIn = 1'b1, iowNIn = 1'b1;
  logic [3:0]  addrLoIn = '0;
  logic [7:0]  dataIn = '0, regRdData = '0;
  logic        xferDone, regWrEn, dataOe, busOe, iorNOut, iowNOut, memrN, memwN, adstb, aen;
  logic [3:0]  regWrSel, regRdSel, addrLoOut, addrMidOut;
  logic [7:0]  regWrData, dataOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  dma_strobe_unit uut (
    .clk(clk), .rst(rst), .busGrant(busGrant), .xferReq(xferReq),
    .xferKind(xferKind), .xferAddr(xferAddr), .readyIn(readyIn),
    .xferDone(xferDone), .csN(csN), .iorNIn(iorNIn), .iowNIn(iowNIn),
    .addrLoIn(addrLoIn), .dataIn(dataIn), .regWrEn(regWrEn),
    .regWrSel(regWrSel), .regWrData(regWrData), .regRdSel(regRdSel),
    .regRdData(regRdData), .dataOut(dataOut), .dataOe(dataOe),
    .busOe(busOe), .addrLoOut(addrLoOut), .addrMidOut(addrMidOut),
    .iorNOut(iorNOut), .iowNOut(iowNOut), .memrN(memrN), .memwN(memwN),
    .adstb(adstb), .aen(aen)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // {iorN, iowN, memrN, memwN} during the strobe phase
  function automatic logic [3:0] expStrobes(input logic [1:0] kind);
    case (kind)
      2'b01:   return 4'b0110;
      2'b10:   return 4'b1001;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [3:0] strobes();
    return {iorNOut, iowNOut, memrN, memwN};
  endfunction

  task automatic runXfer(input logic [1:0] kind, input logic [15:0] addr, input int waits);
    busGrant = 1'b1; xferReq = 1'b1; xferKind = kind; xferAddr = addr;
    readyIn  = (waits == 0);
    step();
    xferReq = 1'b0;
    // address phase
    check("R5 addr aen", aen, 1);
    check("R5 addr adstb", adstb, 0);
    check("R5 addr dataOe", dataOe, 1);
    check("R5 addr hi byte", dataOut, addr[15:8]);
    check("R5 addr lo", addrLoOut, addr[3:0]);
    check("R5 addr mid", addrMidOut, addr[7:4]);
    check("R5 addr strobes", strobes(), 4'hF);
    step();
    // latch phase; a request here must be ignored (R11)
    xferReq = 1'b1;
    check("R5 latch adstb", adstb, 1);
    check("R5 latch hi byte", dataOut, addr[15:8]);
    check("R5 latch strobes", strobes(), 4'hF);
    step();
    xferReq = 1'b0;
    check("R6 strobe kind", strobes(), expStrobes(kind));
    check("R6 dataOe off", dataOe, 0);
    check("R11 no restart", adstb, 0);
    for (int w = 0; w < waits; w++) begin
      step();
      check("R8 stretched", strobes(), expStrobes(kind));
      check("R8 no done", xferDone, 0);
    end
    readyIn = 1'b1;
    step();
    check("R9 release strobes", strobes(), 4'hF);
    check("R9 done", xferDone, 1);
    check("R9 aen held", aen, 1);
    step();
    check("R9 idle done", xferDone, 0);
    check("R9 idle aen", aen, 0);
  endtask

  task automatic slaveWrite(input logic [3:0] sel, input logic [7:0] d, input int hold);
    busGrant = 1'b0; csN = 1'b0; iowNIn = 1'b0; addrLoIn = sel; dataIn = d;
    step();
    addrLoIn = ~sel; dataIn = ~d;
    check("R2 wr pulse", regWrEn, 1);
    check("R2 wr sel", regWrSel, sel);
    check("R2 wr data", regWrData, d);
    for (int h = 0; h < hold; h++) begin
      step();
      check("R2 single pulse", regWrEn, 0);
      check("R2 data kept", regWrData, d);
    end
    iowNIn = 1'b1; csN = 1'b1;
    step();
  endtask

  task automatic slaveRead(input logic [3:0] sel, input logic [7:0] d);
    busGrant = 1'b0; csN = 1'b0; iorNIn = 1'b0; addrLoIn = sel; regRdData = d;
    #1;
    check("R3 rd oe", dataOe, 1);
    check("R3 rd data", dataOut, d);
    check("R3 rd sel", regRdSel, sel);
    step();
    check("R3 no write", regWrEn, 0);
    iorNIn = 1'b1; csN = 1'b1;
    #1;
    check("R3 rd release", dataOe, 0);
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h0D1A5EED));
    step(); step();
    // R1 reset state
    check("R1 strobes", strobes(), 4'hF);
    check("R1 aen", aen, 0);
    check("R1 adstb", adstb, 0);
    check("R1 dataOe", dataOe, 0);
    check("R1 regWrEn", regWrEn, 0);
    check("R1 xferDone", xferDone, 0);
    rst = 1'b0;
    step();
    check("R1 after reset aen", aen, 0);

    // R10 bus enable follows grant
    check("R10 busOe low", busOe, 0);
    busGrant = 1'b1; #1;
    check("R10 busOe high", busOe, 1);
    busGrant = 1'b0; #1;
    check("R10 quiet strobes", strobes(), 4'hF);

    // R11 request without grant
    xferReq = 1'b1; xferKind = 2'b01;
    step();
    check("R11 no grant aen", aen, 0);
    step();
    check("R11 no grant strobes", strobes(), 4'hF);
    xferReq = 1'b0;

    // directed kinds, including R7 verify and spare
    runXfer(2'b01, 16'hA55A, 0);
    runXfer(2'b10, 16'h1234, 3);
    runXfer(2'b00, 16'hFFFF, 1);   // R7
    runXfer(2'b11, 16'h0000, 2);   // R7

    // R4 deselected write and read
    busGrant = 1'b0; csN = 1'b1; iowNIn = 1'b0; iorNIn = 1'b1;
    step();
    check("R4 cs high no wr", regWrEn, 0);
    iowNIn = 1'b1; iorNIn = 1'b0; #1;
    check("R4 cs high no rd", dataOe, 0);
    iorNIn = 1'b1;
    // R4 access while granted
    busGrant = 1'b1; csN = 1'b0; iowNIn = 1'b0;
    step();
    check("R4 granted no wr", regWrEn, 0);
    iowNIn = 1'b1; iorNIn = 1'b0; #1;
    check("R4 granted no rd", dataOe, 0);
    iorNIn = 1'b1; csN = 1'b1; busGrant = 1'b0;
    step();

    // R2 / R3 directed
    slaveWrite(4'h0, 8'h00, 0);
    slaveWrite(4'hF, 8'hFF, 3);
    slaveRead(4'h8, 8'hC3);

    // constrained random mix
    for (int i = 0; i < 60; i++) begin
      int pick;
      pick = $urandom_range(0, 2);
      if (pick == 0)
        runXfer(2'($urandom_range(0, 3)), 16'($urandom), $urandom_range(0, 5));
      else if (pick == 1)
        slaveWrite(4'($urandom), 8'($urandom), $urandom_range(0, 2));
      else
        slaveRead(4'($urandom), 8'($urandom));
    end

    busGrant = 1'b0;
    step();
    check("R10 final quiet", strobes(), 4'hF);
    summary();
  end

endmodule